// File: doc/BRIEF.md
# Paged Register Address Decoder

This block produces the internal register address for a host-visible register file of 64 slots that is arranged as eight pages of eight registers. A single page control register is reachable at offset 0 of every page. It holds a paging flag and a 3-bit page number. With paging on, the upper three address bits come from the stored page number and the lower three come from the host bus or address latch. With paging off, the full 6-bit address comes from the internal address latch.

Each bus access is decoded combinationally and then registered. One cycle after the access, the block presents three outputs. The first is a one-hot select over all 64 slots. The second is the composed address. The third is the read-back value of the page register when that register was read. A write to the page register is applied at the edge that ends the writing access. That access is therefore decoded with the old settings, and only the next access sees the new ones.

Top module: `paged_addr_decoder`

## Requirements
- R1: After reset the page register holds 80h: paging on, page 0. A read of it returns 80h, and an access at low offset 5 selects slot 05h.
- R2: With paging on, an access at low offset 0 reaches the page register whatever page is selected, so it answers at slots 00h, 08h, 10h, 18h, 20h, 28h, 30h and 38h.
- R3: With paging off, a latch address whose three low bits are zero reaches the page register.
- R4: With paging on, the composed address is {page number, low offset}. Page number is bits 5..3 and offset is bits 2..0. The latch address has no effect.
- R5: With paging off, the composed address equals the 6-bit latch address. The low offset from the bus has no effect.
- R6: Page register layout: bit 7 is the paging flag, bits 2..0 are the page number, and bits 6..3 are reserved. Writes to the reserved bits are dropped, and a read returns them as 0.
- R7: A page register write is decoded with the settings in force before it. The new settings apply from the next access.
- R8: One cycle after each access, `regSelect` has exactly one bit set, at the composed address, and `respValid` is 1. In cycles with no access response, `regSelect`, `regAddr` and `rdData` are all zero.
- R9: `rdData` carries the page register value only for a read that reached the page register, and is 0 for any other access. Writes to any other slot leave the page register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| accessValid | input | 1 | A bus access is present this cycle |
| accessWrite | input | 1 | 1 = write access, 0 = read access |
| busLow | input | 3 | Low address bits from the bus pins or the latch |
| latchAddr | input | 6 | Full internal address latch value |
| wrData | input | 8 | Write data |
| respValid | output | 1 | Registered: an access was decoded last cycle |
| regSelect | output | 64 | Registered one-hot slot select |
| regAddr | output | 6 | Registered composed address |
| rdData | output | 8 | Registered page register read-back, else 0 |

## Verification
The bench builds the block with its default parameters: a 6-bit address, a 3-bit offset and 8-bit data. With these settings every one of the 64 select lines can be reached. It sweeps all page and offset pairs in paged mode, with the latch carrying unrelated values. It then sweeps all 64 latch values in flat mode, with the bus offset carrying noise. This covers every mirror of the page register in both modes. It also includes the cycle in which a page write switches between modes, which checks that the writing access keeps the old decode.

// File: rtl/paged_addr_pkg.sv
package paged_addr_pkg;

  // Strobes passed from control to datapath for one bus access.
  typedef struct packed {
    logic capture;    // register the decode of this access
    logic pageWrite;  // load the page register at this edge
    logic pageRead;   // return the page register on rdData
  } ctrlStrobes_t;

  // Bits of the page register that exist: the flag on top and the page field.
  function automatic logic [63:0] keepMask(input int dataW, input int pageW);
    logic [63:0] m;
    m = (64'd1 << pageW) - 64'd1;
    m = m | (64'd1 << (dataW - 1));
    return m;
  endfunction

endpackage

// File: rtl/pa_ctrl.sv
module pa_ctrl
  import paged_addr_pkg::*;
(
  input  logic         accessValid,
  input  logic         accessWrite,
  input  logic         pageHit,
  output ctrlStrobes_t strobes
);

  always_comb begin
    strobes           = '0;
    strobes.capture   = accessValid;
    strobes.pageWrite = accessValid && accessWrite && pageHit;
    strobes.pageRead  = accessValid && !accessWrite && pageHit;
  end

endmodule

// File: rtl/pa_datapath.sv
module pa_datapath
  import paged_addr_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int OFF_W  = 3,
  parameter int DATA_W = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctrlStrobes_t              strobes,
  input  logic [OFF_W-1:0]          busLow,
  input  logic [ADDR_W-1:0]         latchAddr,
  input  logic [DATA_W-1:0]         wrData,
  output logic                      pageHit,
  output logic                      pageEnable,
  output logic [ADDR_W-OFF_W-1:0]   pageNum,
  output logic                      respValid,
  output logic [(1<<ADDR_W)-1:0]    regSelect,
  output logic [ADDR_W-1:0]         regAddr,
  output logic [DATA_W-1:0]         rdData
);

  localparam int PAGE_W = ADDR_W - OFF_W;
  localparam int SLOTS  = 1 << ADDR_W;
  localparam logic [63:0] KEEP64 = keepMask(DATA_W, PAGE_W);
  localparam logic [DATA_W-1:0] KEEP_MASK = KEEP64[DATA_W-1:0];
  localparam logic [DATA_W-1:0] RESET_VAL = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] pageCfg;
  logic [ADDR_W-1:0] composed;
  logic [SLOTS-1:0]  nextSel;

  assign pageEnable = pageCfg[DATA_W-1];
  assign pageNum    = pageCfg[PAGE_W-1:0];

  always_comb begin
    if (pageEnable) composed = {pageNum, busLow};
    else            composed = latchAddr;
  end

  assign pageHit = (composed[OFF_W-1:0] == '0);

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    assign nextSel[g] = strobes.capture && (composed == ADDR_W'(g));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageCfg <= RESET_VAL;
    end else if (strobes.pageWrite) begin
      pageCfg <= wrData & KEEP_MASK;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respValid <= 1'b0;
      regSelect <= '0;
      regAddr   <= '0;
      rdData    <= '0;
    end else begin
      respValid <= strobes.capture;
      regSelect <= nextSel;
      regAddr   <= strobes.capture ? composed : '0;
      rdData    <= strobes.pageRead ? pageCfg : '0;
    end
  end

endmodule

// File: rtl/paged_addr_decoder.sv
module paged_addr_decoder
  import paged_addr_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int OFF_W  = 3,
  parameter int DATA_W = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   accessValid,
  input  logic                   accessWrite,
  input  logic [OFF_W-1:0]       busLow,
  input  logic [ADDR_W-1:0]      latchAddr,
  input  logic [DATA_W-1:0]      wrData,
  output logic                   respValid,
  output logic [(1<<ADDR_W)-1:0] regSelect,
  output logic [ADDR_W-1:0]      regAddr,
  output logic [DATA_W-1:0]      rdData
);

  localparam int PAGE_W = ADDR_W - OFF_W;

  ctrlStrobes_t      strobes;
  logic              pageHit;
  logic              pageEnable;
  logic [PAGE_W-1:0] pageNum;

  pa_ctrl u_ctrl (
    .accessValid (accessValid),
    .accessWrite (accessWrite),
    .pageHit     (pageHit),
    .strobes     (strobes)
  );

  pa_datapath #(
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .busLow     (busLow),
    .latchAddr  (latchAddr),
    .wrData     (wrData),
    .pageHit    (pageHit),
    .pageEnable (pageEnable),
    .pageNum    (pageNum),
    .respValid  (respValid),
    .regSelect  (regSelect),
    .regAddr    (regAddr),
    .rdData     (rdData)
  );

endmodule

// File: rtl/pa_checker.sv
module pa_checker #(
  parameter int ADDR_W = 6,
  parameter int OFF_W  = 3,
  parameter int DATA_W = 8
) (
  input logic                         clk,
  input logic                         rstN,
  input logic                         accessValid,
  input logic                         accessWrite,
  input logic [OFF_W-1:0]             busLow,
  input logic [ADDR_W-1:0]            latchAddr,
  input logic [DATA_W-1:0]            wrData,
  input logic                         pageEnable,
  input logic [ADDR_W-OFF_W-1:0]      pageNum,
  input logic                         respValid,
  input logic [(1<<ADDR_W)-1:0]       regSelect,
  input logic [ADDR_W-1:0]            regAddr,
  input logic [DATA_W-1:0]            rdData
);

  localparam int PAGE_W = ADDR_W - OFF_W;

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> ($countones(regSelect) == 1 && regSelect[regAddr])); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !respValid |-> (regSelect == '0 && regAddr == '0 && rdData == '0)); // R8

  AST_PAGED_COMPOSE: assert property (@(posedge clk) disable iff (!rstN)
    (accessValid && pageEnable) |=> (respValid && regAddr == {$past(pageNum), $past(busLow)})); // R4

  AST_FLAT_COMPOSE: assert property (@(posedge clk) disable iff (!rstN)
    (accessValid && !pageEnable) |=> (respValid && regAddr == $past(latchAddr))); // R5

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    rdData[DATA_W-2:PAGE_W] == '0); // R6

  AST_WRITE_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    (accessValid && accessWrite && regAddr == regAddr && (pageEnable ? busLow == '0 : latchAddr[OFF_W-1:0] == '0))
    |=> (pageEnable == $past(wrData[DATA_W-1]) && pageNum == $past(wrData[PAGE_W-1:0]))); // R7

  AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(accessValid && accessWrite) |=> ($stable(pageEnable) && $stable(pageNum))); // R9

endmodule

bind paged_addr_decoder pa_checker #(
  .ADDR_W (ADDR_W),
  .OFF_W  (OFF_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .accessValid (accessValid),
  .accessWrite (accessWrite),
  .busLow      (busLow),
  .latchAddr   (latchAddr),
  .wrData      (wrData),
  .pageEnable  (pageEnable),
  .pageNum     (pageNum),
  .respValid   (respValid),
  .regSelect   (regSelect),
  .regAddr     (regAddr),
  .rdData      (rdData)
);

// File: tb/tb_paged_addr_decoder.sv
module tb_paged_addr_decoder;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        accessValid = 1'b0;
  logic        accessWrite = 1'b0;
  logic [2:0]  busLow = '0;
  logic [5:0]  latchAddr = '0;
  logic [7:0]  wrData = '0;
  logic        respValid;
  logic [63:0] regSelect;
  logic [5:0]  regAddr;
  logic [7:0]  rdData;

  int checks = 0;
  int errors = 0;
  bit monitorOn = 1'b0;
  bit finished = 1'b0;

  // Bench model of the page register
  bit       mEn = 1'b1;
  bit [2:0] mPage = 3'd0;

  logic [5:0] expAddrQ[$];
  logic [7:0] expRdQ[$];
  string      tagQ[$];

  paged_addr_decoder dut (
    .clk         (clk),
    .rstN        (rstN),
    .accessValid (accessValid),
    .accessWrite (accessWrite),
    .busLow      (busLow),
    .latchAddr   (latchAddr),
    .wrData      (wrData),
    .respValid   (respValid),
    .regSelect   (regSelect),
    .regAddr     (regAddr),
    .rdData      (rdData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Driver: presents one access for one cycle and queues the expected result.
  task automatic access(input bit wr, input logic [2:0] low, input logic [5:0] lat,
                        input logic [7:0] data, input string tag);
    logic [5:0] ea;
    logic [7:0] er;
    bit hit;
    @(negedge clk);
    accessValid = 1'b1;
    accessWrite = wr;
    busLow      = low;
    latchAddr   = lat;
    wrData      = data;
    ea  = mEn ? {mPage, low} : lat;
    hit = (ea[2:0] == 3'd0);
    er  = (!wr && hit) ? {mEn, 4'b0000, mPage} : 8'h00;
    expAddrQ.push_back(ea);
    expRdQ.push_back(er);
    tagQ.push_back(tag);
    if (wr && hit) begin
      mEn   = data[7];
      mPage = data[2:0];
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      accessValid = 1'b0;
      accessWrite = 1'b0;
      busLow      = 3'($urandom);
      latchAddr   = 6'($urandom);
      wrData      = 8'($urandom);
    end
  endtask

  // Monitor: compares every response against the queued expectation.
  initial begin
    forever begin
      @(negedge clk);
      if (monitorOn) begin
        if (respValid) begin
          if (expAddrQ.size() == 0) begin
            check(1'b0, "R8", "unexpected response", 64'(regAddr), 64'h0);
          end else begin
            logic [5:0] ea;
            logic [7:0] er;
            string t;
            ea = expAddrQ.pop_front();
            er = expRdQ.pop_front();
            t  = tagQ.pop_front();
            check(regAddr == ea, t, "regAddr", 64'(regAddr), 64'(ea));
            check(regSelect == (64'd1 << ea), "R8", "regSelect", regSelect, 64'd1 << ea);
            check(rdData == er, t == "R6" ? "R6" : "R9", "rdData", 64'(rdData), 64'(er));
          end
        end else begin
          check(regSelect == '0 && regAddr == '0 && rdData == '0, "R8",
                "idle outputs", regSelect, 64'h0);
        end
      end
    end
  end

  // Watchdog
  initial begin
    for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=done", WATCHDOG);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state at the ports
    check(respValid == 1'b0, "R1", "respValid after reset", 64'(respValid), 64'h0);
    check(regSelect == '0, "R1", "regSelect after reset", regSelect, 64'h0);
    monitorOn = 1'b1;

    // R1: reset value 80h, page 0
    access(1'b0, 3'd0, 6'h2A, 8'h00, "R1");
    access(1'b0, 3'd5, 6'h2A, 8'h00, "R1");
    idle(1);

    // R4, R2, R7: every page and offset, latch carrying noise
    for (int p = 0; p < 8; p++) begin
      access(1'b1, 3'd0, 6'($urandom), 8'h80 | 8'(p), "R7");
      for (int o = 0; o < 8; o++)
        access(1'b0, 3'(o), 6'($urandom), 8'($urandom), o == 0 ? "R2" : "R4");
    end
    idle(2);

    // R6: reserved bits dropped on write, read back as zero
    access(1'b1, 3'd0, 6'h00, 8'hFF, "R6");
    access(1'b0, 3'd0, 6'h00, 8'h00, "R6");
    // R9: write to a non-page slot leaves the page register alone
    access(1'b1, 3'd3, 6'h00, 8'h00, "R9");
    access(1'b0, 3'd0, 6'h00, 8'h00, "R9");
    // R7: switch to flat mode; the writing access still decodes paged
    access(1'b1, 3'd0, 6'h31, 8'h7B, "R7");
    access(1'b0, 3'd0, 6'h10, 8'h00, "R3");
    idle(1);

    // R5, R3: flat sweep with bus offset noise
    for (int a = 0; a < 64; a++)
      access(1'b0, 3'($urandom), 6'(a), 8'h00, (a % 8 == 0) ? "R3" : "R5");
    idle(1);

    // R7: back to paged page 2 from flat mode, then check the new decode
    access(1'b1, 3'd5, 6'h18, 8'h82, "R7");
    access(1'b0, 3'd1, 6'h3F, 8'h00, "R7");
    access(1'b0, 3'd0, 6'h3F, 8'h00, "R2");
    idle(3);

    finished = 1'b1;
    check(expAddrQ.size() == 0, "R8", "pending responses", 64'(expAddrQ.size()), 64'h0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule